// File: doc/BRIEF.md
# Iterative 64-bit Divider with Overflow Detection

This block is a multi-cycle restoring divider placed beside an execute stage. The requesting stage has already reduced both operands to magnitudes. It presents them together with a start pulse and a set of mode flags:
- signed or unsigned,
- 32-bit or 64-bit width,
- extended dividend,
- quotient or remainder,
- whether the final result must be negative.

The requester then stalls until the one-cycle `done` pulse arrives. On that pulse the block delivers the write value and a 32-bit condition field.

Every operation uses the same number of steps, whatever its width. The datapath is one bit wider than the operands and runs one step beyond the operand width. That extra step yields the quotient bit of weight 2^64, which is the overflow indication. Results that overflow, or that do not fit the range of the selected mode, are replaced by zero with only the equal flag set. Sign correction and the 32-bit result formatting are applied in a final output cycle.

Top module: `iter_divider`

## Requirements
- R1: `rst` is synchronous and active high. While it is high and in the cycle after it falls, `done`, `wr_data` and `cr_data` are zero. A `start` in the first cycle after reset is accepted.
- R2: `done` is high for exactly one cycle. It rises at the 66th rising edge after the edge that sampled the accepted `start`.
- R3: A `start` that arrives while an operation is in progress is ignored. Only one `done` follows, and it carries the result of the accepted operation.
- R4: With `op_signed`=0 and `op_word`=0, `wr_data` is the 64-bit quotient when `op_mod`=0 and the remainder when `op_mod`=1.
- R5: When the widened dividend is at least 2^64 times the divisor, `wr_data` is 0 and `cr_data` is 0x20000000. This includes a zero divisor.
- R6: For a divide, the quotient magnitude must fit the selected range, otherwise the result is forced as in R5. The ranges are:
  - unsigned 32-bit: below 2^32.
  - signed with `neg_res`=1: at most 2^(w-1).
  - signed with `neg_res`=0: below 2^(w-1).
  - Here w is 32 or 64.
- R7: With `op_signed`=1 and `neg_res`=1 the result is the two's complement negation of the magnitude. `neg_res` has no effect when `op_signed`=0.
- R8: For a 32-bit signed divide, bits 63:32 of `wr_data` are zero. The condition field is taken from that 64-bit value, so its less-than bit is never set.
- R9: For a 32-bit signed remainder with a negative result, bits 63:32 of `wr_data` are all ones.
- R10: `cr_data` holds exactly one set flag, and bits 28:0 are zero. The flags are:
  - bit 31, less-than: `wr_data[63]`.
  - bit 30, greater-than: `wr_data` is nonzero and bit 63 is clear.
  - bit 29, equal: `wr_data` is zero.
- R11: With `op_ext`=1 and `op_mod`=0, the dividend is multiplied by 2^64 in 64-bit mode and by 2^32 in 32-bit mode. `op_ext` has no effect when `op_mod`=1.
- R12: With `op_word`=1, bits 63:32 of both `dvd_mag` and `dvs_mag` are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation; ignored unless idle |
| dvd_mag | input | 64 | Dividend magnitude |
| dvs_mag | input | 64 | Divisor magnitude |
| op_signed | input | 1 | Signed operation |
| op_word | input | 1 | 32-bit operation |
| op_ext | input | 1 | Extended dividend (divide only) |
| op_mod | input | 1 | Return remainder instead of quotient |
| neg_res | input | 1 | Result must be negated (signed only) |
| wr_data | output | 64 | Result value |
| cr_data | output | 32 | Condition field (LT bit 31, GT bit 30, EQ bit 29) |
| done | output | 1 | One-cycle result strobe |

## Verification
The assertions check the following on every cycle:
- the reset state;
- the single-cycle strobe and its fixed distance from the accepted start;
- that a start during a run neither restarts nor shortens it;
- that a lost remainder bit only occurs once overflow has been flagged;
- that any rejected result becomes zero with only the equal flag set;
- that the condition field agrees with the write value and is clear of less-than for 32-bit signed divides.

Only the bench's scenarios can show the arithmetic itself. These include:
- the quotient and remainder values;
- where the range limits fall for each mode, including the most negative representable results;
- the extended-dividend scaling and its absence for remainders;
- the masking of upper operand bits in 32-bit mode;
- the upper-half fill for 32-bit signed results.

// File: rtl/div_pkg.sv
package div_pkg;

  // Condition field layout
  localparam int CRW   = 32;
  localparam int CR_LT = 31;
  localparam int CR_GT = 30;
  localparam int CR_EQ = 29;

  // Flags that steer output formatting
  typedef struct packed {
    logic sgn;
    logic word;
    logic modu;
    logic neg;
  } div_mode_t;

  // Full request: dividend placement plus formatting mode
  typedef struct packed {
    logic      ext;
    div_mode_t mode;
  } div_op_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } div_st_e;

endpackage

// File: rtl/div_ctrl.sv
module div_ctrl
  import div_pkg::*;
#(
  parameter int STEPS = 65
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic accept,
  output logic step_en,
  output logic last_step,
  output logic fin,
  output logic busy
);

  localparam int CW = $clog2(STEPS + 1);

  div_st_e       st_q;
  logic [CW-1:0] cnt_q;

  always_comb begin
    accept    = start && (st_q == ST_IDLE);
    step_en   = (st_q == ST_RUN);
    last_step = step_en && (cnt_q == CW'(STEPS - 1));
    fin       = (st_q == ST_FIN);
    busy      = (st_q != ST_IDLE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (start) begin
            st_q  <= ST_RUN;
            cnt_q <= '0;
          end
        end
        ST_RUN: begin
          if (last_step) st_q <= ST_FIN;
          else           cnt_q <= cnt_q + CW'(1);
        end
        ST_FIN:  st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/div_core.sv
module div_core
  import div_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic            step,
  input  logic [XLEN-1:0] dvd_in,
  input  logic [XLEN-1:0] dvs_in,
  input  div_op_t         op_in,
  output logic [XLEN-1:0] quot_q,
  output logic [XLEN-1:0] rem_q,
  output logic            ovf_q,
  output logic            rem_spill,
  output div_mode_t       mode_q
);

  localparam int HALF = XLEN / 2;
  localparam int NW   = 2 * XLEN;

  // Keep only the low half of an operand in 32-bit mode
  function automatic logic [XLEN-1:0] trim_word(input logic [XLEN-1:0] v,
                                                input logic word);
    return word ? {{HALF{1'b0}}, v[HALF-1:0]} : v;
  endfunction

  // Position the dividend inside the double-width numerator
  function automatic logic [NW-1:0] place_num(input logic [XLEN-1:0] a,
                                              input logic word,
                                              input logic ext);
    if (!ext) return {{XLEN{1'b0}}, a};
    if (word) return {{HALF{1'b0}}, a, {HALF{1'b0}}};
    return {a, {XLEN{1'b0}}};
  endfunction

  logic [XLEN-1:0] rem_r, quot_r, dvs_r;
  logic [XLEN:0]   low_r;
  logic            first_r, lead_r;
  div_mode_t       mode_r;

  logic [NW-1:0]   num_init;
  logic [XLEN:0]   trial;
  logic [XLEN+1:0] diff;
  logic            ge;

  assign num_init = place_num(trim_word(dvd_in, op_in.mode.word),
                              op_in.mode.word,
                              op_in.ext & ~op_in.mode.modu);

  always_comb begin
    trial     = {rem_r, low_r[XLEN]};
    diff      = {1'b0, trial} - {2'b00, dvs_r};
    ge        = ~diff[XLEN+1];
    // a set bit here would be dropped from the partial remainder
    rem_spill = step & ge & diff[XLEN];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_r   <= '0;
      quot_r  <= '0;
      dvs_r   <= '0;
      low_r   <= '0;
      first_r <= 1'b0;
      lead_r  <= 1'b0;
      mode_r  <= '0;
    end else if (load) begin
      rem_r   <= {1'b0, num_init[NW-1:XLEN+1]};
      low_r   <= num_init[XLEN:0];
      quot_r  <= '0;
      dvs_r   <= trim_word(dvs_in, op_in.mode.word);
      first_r <= 1'b1;
      lead_r  <= 1'b0;
      mode_r  <= op_in.mode;
    end else if (step) begin
      rem_r   <= ge ? diff[XLEN-1:0] : trial[XLEN-1:0];
      low_r   <= {low_r[XLEN-1:0], 1'b0};
      quot_r  <= {quot_r[XLEN-2:0], ge};
      first_r <= 1'b0;
      if (first_r) lead_r <= ge;
    end
  end

  assign quot_q = quot_r;
  assign rem_q  = rem_r;
  assign ovf_q  = lead_r;
  assign mode_q = mode_r;

endmodule

// File: rtl/div_post.sv
module div_post
  import div_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            fin,
  input  logic [XLEN-1:0] quot,
  input  logic [XLEN-1:0] rem,
  input  logic            ovf,
  input  div_mode_t       mode,
  output logic [XLEN-1:0] wr_data,
  output logic [CRW-1:0]  cr_data,
  output logic            done,
  output logic            bad
);

  localparam int HALF = XLEN / 2;

  // Does the quotient magnitude fit the mode's representable range?
  function automatic logic quot_fits(input logic [XLEN-1:0] q,
                                     input div_mode_t m);
    logic [XLEN-1:0] lim;
    if (!m.sgn) return m.word ? (q[XLEN-1:HALF] == '0) : 1'b1;
    lim = m.word ? (XLEN'(1) << (HALF - 1)) : (XLEN'(1) << (XLEN - 1));
    return m.neg ? (q <= lim) : (q < lim);
  endfunction

  // Apply sign and the 32-bit signed-divide upper clear
  function automatic logic [XLEN-1:0] shape_out(input logic [XLEN-1:0] mag,
                                                input div_mode_t m);
    logic [XLEN-1:0] v;
    v = (m.sgn && m.neg) ? (XLEN'(0) - mag) : mag;
    if (m.sgn && m.word && !m.modu) v[XLEN-1:HALF] = '0;
    return v;
  endfunction

  function automatic logic [CRW-1:0] cr_of(input logic [XLEN-1:0] v);
    logic [CRW-1:0] c;
    c        = '0;
    c[CR_LT] = v[XLEN-1];
    c[CR_GT] = ~v[XLEN-1] & (|v);
    c[CR_EQ] = (v == '0);
    return c;
  endfunction

  logic [XLEN-1:0] res;

  always_comb begin
    bad = ovf | (~mode.modu & ~quot_fits(quot, mode));
    res = bad ? '0 : shape_out(mode.modu ? rem : quot, mode);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_data <= '0;
      cr_data <= '0;
      done    <= 1'b0;
    end else begin
      done <= fin;
      if (fin) begin
        wr_data <= res;
        cr_data <= cr_of(res);
      end
    end
  end

endmodule

// File: rtl/iter_divider.sv
module iter_divider
  import div_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [XLEN-1:0] dvd_mag,
  input  logic [XLEN-1:0] dvs_mag,
  input  logic            op_signed,
  input  logic            op_word,
  input  logic            op_ext,
  input  logic            op_mod,
  input  logic            neg_res,
  output logic [XLEN-1:0] wr_data,
  output logic [CRW-1:0]  cr_data,
  output logic            done
);

  // operand width steps plus one for the overflow weight
  localparam int STEPS = XLEN + 1;

  div_op_t         op_in;
  div_mode_t       mode_q;
  logic            accept, step_en, last_step, fin, busy;
  logic [XLEN-1:0] quot_q, rem_q;
  logic            ovf_q, rem_spill, bad;

  always_comb begin
    op_in.ext       = op_ext;
    op_in.mode.sgn  = op_signed;
    op_in.mode.word = op_word;
    op_in.mode.modu = op_mod;
    op_in.mode.neg  = neg_res;
  end

  div_ctrl #(.STEPS(STEPS)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .accept    (accept),
    .step_en   (step_en),
    .last_step (last_step),
    .fin       (fin),
    .busy      (busy)
  );

  div_core #(.XLEN(XLEN)) u_core (
    .clk       (clk),
    .rst       (rst),
    .load      (accept),
    .step      (step_en),
    .dvd_in    (dvd_mag),
    .dvs_in    (dvs_mag),
    .op_in     (op_in),
    .quot_q    (quot_q),
    .rem_q     (rem_q),
    .ovf_q     (ovf_q),
    .rem_spill (rem_spill),
    .mode_q    (mode_q)
  );

  div_post #(.XLEN(XLEN)) u_post (
    .clk     (clk),
    .rst     (rst),
    .fin     (fin),
    .quot    (quot_q),
    .rem     (rem_q),
    .ovf     (ovf_q),
    .mode    (mode_q),
    .wr_data (wr_data),
    .cr_data (cr_data),
    .done    (done),
    .bad     (bad)
  );

endmodule

// File: rtl/iter_divider_chk.sv
module iter_divider_chk
  import div_pkg::*;
#(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst,
  input logic            start,
  input logic            accept,
  input logic            busy,
  input logic            step_en,
  input logic            last_step,
  input logic            fin,
  input logic            done,
  input logic            ovf,
  input logic            bad,
  input logic            rem_spill,
  input logic            m_sgn,
  input logic            m_word,
  input logic            m_modu,
  input logic [XLEN-1:0] wr_data,
  input logic [CRW-1:0]  cr_data
);

  localparam int HALF = XLEN / 2;
  localparam int LW   = $clog2(XLEN + 4) + 1;

  // cycles since the accepting edge, used for the latency window
  logic [LW-1:0] lat_q;

  always_ff @(posedge clk) begin
    if (rst)                 lat_q <= '0;
    else if (accept)         lat_q <= LW'(1);
    else if (done)           lat_q <= '0;
    else if (lat_q != '0)    lat_q <= lat_q + LW'(1);
  end

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (!done && !busy && wr_data == '0 && cr_data == '0));

  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_latency_R2: assert property (@(posedge clk) disable iff (rst)
    done |-> (lat_q == LW'(XLEN + 3)));

  assert_last_to_fin_R2: assert property (@(posedge clk) disable iff (rst)
    last_step |=> (fin && !done));

  assert_start_ignored_R3: assert property (@(posedge clk) disable iff (rst)
    (start && step_en && !last_step) |=> (step_en && !done));

  assert_spill_only_ovf_R5: assert property (@(posedge clk) disable iff (rst)
    rem_spill |-> ovf);

  assert_bad_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (fin && bad) |=> (done && wr_data == '0 && cr_data == (CRW'(1) << CR_EQ)));

  assert_cr_flags_R10: assert property (@(posedge clk) disable iff (rst)
    done |-> (cr_data[CR_EQ] == (wr_data == '0) &&
              cr_data[CR_LT] == wr_data[XLEN-1] &&
              $countones(cr_data[CR_LT:CR_EQ]) == 1 &&
              cr_data[CRW-4:0] == '0));

  assert_word_sdiv_R8: assert property (@(posedge clk) disable iff (rst)
    (done && m_sgn && m_word && !m_modu) |->
      (wr_data[XLEN-1:HALF] == '0 && !cr_data[CR_LT]));

endmodule

bind iter_divider iter_divider_chk #(.XLEN(XLEN)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .accept    (accept),
  .busy      (busy),
  .step_en   (step_en),
  .last_step (last_step),
  .fin       (fin),
  .done      (done),
  .ovf       (ovf_q),
  .bad       (bad),
  .rem_spill (rem_spill),
  .m_sgn     (mode_q.sgn),
  .m_word    (mode_q.word),
  .m_modu    (mode_q.modu),
  .wr_data   (wr_data),
  .cr_data   (cr_data)
);

// File: tb/iter_divider_test.sv
module iter_divider_test;

  localparam int CLK_PERIOD = 10;
  localparam int LAT        = 66;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [63:0] dvd = '0, dvs = '0;
  logic        op_signed = 1'b0, op_word = 1'b0, op_ext = 1'b0;
  logic        op_mod = 1'b0, neg_res = 1'b0;
  logic [63:0] wr_data;
  logic [31:0] cr_data;
  logic        done;

  int vectors = 0;
  int miscompares = 0;
  int cyc = 0;

  logic [63:0] exp_wr[$];
  logic [31:0] exp_cr[$];
  int          exp_t0[$];
  string       exp_tag[$];

  iter_divider uut (
    .clk(clk), .rst(rst), .start(start), .dvd_mag(dvd), .dvs_mag(dvs),
    .op_signed(op_signed), .op_word(op_word), .op_ext(op_ext),
    .op_mod(op_mod), .neg_res(neg_res),
    .wr_data(wr_data), .cr_data(cr_data), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] expv);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  // Reference model written from the requirements
  task automatic model(input logic [63:0] x, input logic [63:0] y,
                       input bit sg, input bit wd, input bit ex,
                       input bit md, input bit ng,
                       output logic [63:0] w, output logic [31:0] c);
    logic [127:0] num, q, r;
    logic [63:0]  a, b, mag, val, lim;
    bit           rej;
    a = wd ? {32'h0, x[31:0]} : x;
    b = wd ? {32'h0, y[31:0]} : y;
    num = {64'h0, a};
    if (ex && !md) num = wd ? (num << 32) : (num << 64);
    if (b == 64'h0) begin
      rej = 1; q = '0; r = '0;
    end else begin
      q = num / {64'h0, b};
      r = num % {64'h0, b};
      rej = (q[127:64] != 64'h0);
    end
    if (!rej && !md) begin
      if (!sg) begin
        if (wd && q[63:32] != 32'h0) rej = 1;
      end else begin
        lim = wd ? 64'h0000_0000_8000_0000 : 64'h8000_0000_0000_0000;
        if (ng ? (q[63:0] > lim) : (q[63:0] >= lim)) rej = 1;
      end
    end
    mag = md ? r[63:0] : q[63:0];
    val = (sg && ng) ? (64'h0 - mag) : mag;
    if (sg && wd && !md) val[63:32] = 32'h0;
    if (rej) val = 64'h0;
    w = val;
    if (val[63])            c = 32'h8000_0000;
    else if (val != 64'h0)  c = 32'h4000_0000;
    else                    c = 32'h2000_0000;
  endtask

  task automatic issue(input logic [63:0] x, input logic [63:0] y,
                       input bit sg, input bit wd, input bit ex,
                       input bit md, input bit ng, input string tag);
    logic [63:0] w;
    logic [31:0] c;
    while (exp_wr.size() != 0) @(negedge clk);
    @(negedge clk);
    model(x, y, sg, wd, ex, md, ng, w, c);
    exp_wr.push_back(w);
    exp_cr.push_back(c);
    exp_t0.push_back(cyc);
    exp_tag.push_back(tag);
    dvd = x; dvs = y;
    op_signed = sg; op_word = wd; op_ext = ex; op_mod = md; neg_res = ng;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // Monitor: pops expectations as results appear
  logic prev_done = 1'b0;
  always @(negedge clk) begin
    if (!rst) begin
      if (done && prev_done)
        check(0, "R2 done held more than one cycle", 64'(done), 64'h0);
      if (done && !prev_done) begin
        if (exp_wr.size() == 0) begin
          check(0, "R3 unexpected done", wr_data, 64'h0);
        end else begin
          logic [63:0] ew;
          logic [31:0] ec;
          int          t0;
          string       tg;
          ew = exp_wr.pop_front();
          ec = exp_cr.pop_front();
          t0 = exp_t0.pop_front();
          tg = exp_tag.pop_front();
          check(wr_data == ew, tg, wr_data, ew);
          check(cr_data == ec, {"R10 cr ", tg}, 64'(cr_data), 64'(ec));
          check((cyc - t0) == LAT + 1, {"R2 latency ", tg},
                64'(cyc - t0), 64'(LAT + 1));
        end
      end
    end
    prev_done <= done;
  end

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual still running, expected finished");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(done == 1'b0 && wr_data == 64'h0 && cr_data == 32'h0,
          "R1 reset outputs", wr_data, 64'h0);
    rst = 1'b0;
    // R1: accepted in the very first cycle after reset
    dvd = 64'd100; dvs = 64'd7; start = 1'b1;
    exp_wr.push_back(64'd14); exp_cr.push_back(32'h4000_0000);
    exp_t0.push_back(cyc); exp_tag.push_back("R1 first start after reset");
    @(negedge clk);
    start = 1'b0;

    issue(64'd100, 64'd7, 0, 0, 0, 1, 0, "R4 unsigned remainder");
    issue(64'hFFFF_FFFF_FFFF_FFFF, 64'd3, 0, 0, 0, 0, 0, "R4 full-width quotient");
    issue(64'd12345, 64'd0, 0, 0, 0, 0, 0, "R5 zero divisor");
    issue(64'd12345, 64'd0, 1, 1, 0, 1, 1, "R5 zero divisor remainder");
    issue(64'd5, 64'd3, 0, 0, 1, 0, 0, "R5 R11 extended dividend not below divisor");
    issue(64'd1, 64'd3, 0, 0, 1, 0, 0, "R11 extended 64-bit quotient");
    issue(64'd1, 64'd3, 0, 1, 1, 0, 0, "R11 extended 32-bit quotient");
    issue(64'd100, 64'd7, 0, 0, 1, 1, 0, "R11 extended ignored for remainder");
    issue(64'd100, 64'd7, 1, 0, 0, 0, 1, "R7 negative quotient");
    issue(64'd100, 64'd7, 1, 0, 0, 1, 1, "R7 negative remainder");
    issue(64'd100, 64'd7, 0, 0, 0, 0, 1, "R7 negate flag ignored when unsigned");
    issue(64'h8000_0000_0000_0000, 64'd1, 1, 0, 0, 0, 1, "R6 most negative 64-bit fits");
    issue(64'h8000_0000_0000_0000, 64'd1, 1, 0, 0, 0, 0, "R6 positive 2^63 rejected");
    issue(64'h8000_0000, 64'd1, 1, 1, 0, 0, 0, "R6 positive 2^31 rejected in word mode");
    issue(64'd3, 64'd2, 0, 1, 1, 0, 0, "R6 unsigned word quotient too large");
    issue(64'd7, 64'd2, 1, 1, 0, 0, 1, "R8 word signed divide upper cleared");
    issue(64'd7, 64'd2, 1, 1, 0, 1, 1, "R9 word signed remainder upper ones");
    issue(64'hDEAD_0000_0000_0064, 64'hFFFF_0000_0000_0007, 0, 1, 0, 0, 0,
          "R12 upper operand bits ignored");

    // R3: a second start while busy must be ignored
    issue(64'd1000, 64'd10, 0, 0, 0, 0, 0, "R3 first operation kept");
    repeat (10) @(negedge clk);
    dvd = 64'd9; dvs = 64'd1; op_mod = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (exp_wr.size() != 0) @(negedge clk);
    repeat (LAT + 10) @(negedge clk);
    check(done == 1'b0, "R3 no second done", 64'(done), 64'h0);

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule